// File: doc/BRIEF.md
# Downstream Bridge Window Decoder

This block sits in a bridge between a 40-bit host fabric and a 32-bit expansion bus. Each downstream request enters with an address, a kind (memory or I/O) and a set of attribute flags. The block decides whether the bridge claims the request and which window it hit. It produces the expansion-bus address and says whether the request may be forwarded. Packet parsing, flow control and the expansion bus protocol itself are handled elsewhere.

Software programs the block through a plain register write port with a combinational read-back. The register file holds two memory windows and an I/O range limit:

- A non-prefetchable window, with a base register and a control register.
- A prefetchable window, with a base register and a control register.
- An I/O size register that limits the claimed I/O range.

Each base sits at 1 MB granularity. Each window has its own enable and its own three attribute-permit bits. A read-only identification word returns a capability type and a mapping type.

Requests and responses use valid/ready handshakes. The decode result is registered, so a response appears one cycle after the request is accepted.

Top module: `brwin_decoder`

## Requirements
- R1: Register offset 0 is read-only. It reads 0x00000008: bits 4:0 hold the capability type 5'b01000 and bits 7:5 hold the mapping type 0. Writes to offset 0, and to offsets 6 and 7, change nothing, and those unused offsets read 0.
- R2: The register layout is as follows, and these are the reset values:
  - Offset 1 is the non-prefetchable base, bits 19:0, holding host address bits 39:20. It resets to 0.
  - Offset 2 is the non-prefetchable control. Bit 0 is enable, bit 1 permits NonCoherent, bit 2 permits Isochronous and bit 3 permits Compatibility. It resets to 0.
  - Offsets 3 and 4 are the prefetchable base and control, with the same layout. Both reset to 0.
  - Offset 5 is the I/O size, bits 4:0. It resets to 25.
  - Written values read back masked to these fields.
- R3: A memory request (kind 0) hits the enabled non-prefetchable window when (addr[39:20] - base) mod 2^20 is below 2^NP_SIZE_LOG2. On a hit, rsp_claim is 1, rsp_win is 1, and rsp_addr is addr - (base << 20), truncated to 32 bits.
- R4: The prefetchable window follows the same rule using PF_SIZE_LOG2, and reports rsp_win = 2.
- R5: A window whose enable bit is 0 never claims a request, whatever its base.
- R6: When a memory address falls in both enabled windows, the non-prefetchable window is selected.
- R7: Attribute bit 0 is NonCoherent, bit 1 is Isochronous and bit 2 is Compatibility. Suppose a request hits the selected window but carries an attribute bit that the window does not permit:
  - rsp_claim is 1.
  - rsp_err is 1.
  - rsp_fwd is 0.

  Otherwise a claimed request has rsp_err = 0 and rsp_fwd = 1.
- R8: An I/O request (kind 1) takes addr[24:0] as its offset and ignores bits 39:25.
  - It is claimed when the offset is below 2^io_size. A claimed I/O request has rsp_win = 3, rsp_addr equal to the offset and rsp_err = 0, and attributes are not checked.
  - A write of a value above 25 to the I/O size register stores 25.
- R9: An unclaimed request responds with rsp_claim, rsp_win, rsp_addr, rsp_err and rsp_fwd all 0.
- R10: The request and response handshakes behave as follows:
  - A request accepted on a clock edge (req_valid and req_ready both 1) produces rsp_valid = 1 after that edge.
  - req_ready is 1 whenever there is no pending response or the pending response is being taken.
  - While rsp_valid is 1 and rsp_ready is 0, all response outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register offset for write and read |
| cfg_wdata | input | CFG_DW | Register write data |
| cfg_rdata | output | CFG_DW | Combinational read data at cfg_addr |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | HADDR_W | Host address |
| req_io | input | 1 | Request kind: 0 memory, 1 I/O |
| req_attr | input | 3 | Attributes: bit0 NonCoherent, bit1 Isochronous, bit2 Compatibility |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_claim | output | 1 | Request hit an enabled window or the I/O range |
| rsp_win | output | 2 | 0 none, 1 non-prefetchable, 2 prefetchable, 3 I/O |
| rsp_addr | output | EADDR_W | Translated expansion-bus address |
| rsp_err | output | 1 | Attribute not permitted by the hit window |
| rsp_fwd | output | 1 | Request may be forwarded |

## Verification
The bench builds the decoder with NP_SIZE_LOG2 = 2 (4 MB) and PF_SIZE_LOG2 = 3 (8 MB). These sizes put both the first and the last byte of each window, and the overlap of the two windows, within a handful of addresses next to one programmed base. The I/O side keeps its full 25-bit space, so the clamp at 25 and the extremes io_size = 0 and io_size = 25 can both be reached. A periodic response stall, applied during a burst, exercises the hold and ready behaviour.

// File: rtl/brwin_pkg.sv
// Package: shared types and constants for the downstream bridge window decoder.
// Assumes attribute and control encodings match the register layout in the brief.
package brwin_pkg;

    localparam logic [4:0] CAP_TYPE_ID = 5'b01000;
    localparam logic [2:0] MAP_TYPE_ID = 3'b000;

    localparam int REG_ID      = 0;
    localparam int REG_NP_BASE = 1;
    localparam int REG_NP_CTL  = 2;
    localparam int REG_PF_BASE = 3;
    localparam int REG_PF_CTL  = 4;
    localparam int REG_IO_SIZE = 5;

    localparam int NUM_WIN = 2;

    typedef struct packed {
        logic compat;
        logic iso;
        logic noncoh;
    } attr_t;

    typedef struct packed {
        attr_t permit;
        logic  en;
    } winctl_t;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_NP   = 2'd1,
        WIN_PF   = 2'd2,
        WIN_IO   = 2'd3
    } win_e;

endpackage

// File: rtl/brwin_regs.sv
// Module: configuration register file for the window decoder.
// Holds both window bases and controls plus the I/O size limit; reads are
// combinational, writes take effect on the next clock edge.
// Assumes CFG_DW >= BASE_W and CFG_DW >= 8.
module brwin_regs
    import brwin_pkg::*;
#(
    parameter int CFG_AW = 3,
    parameter int CFG_DW = 32,
    parameter int BASE_W = 20,
    parameter int IO_AW  = 25,
    parameter int IOSZ_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic [BASE_W-1:0] np_base,
    output winctl_t           np_ctl,
    output logic [BASE_W-1:0] pf_base,
    output winctl_t           pf_ctl,
    output logic [IOSZ_W-1:0] io_size
);

    localparam logic [IOSZ_W-1:0] IO_MAX = IOSZ_W'(IO_AW);

    logic [IOSZ_W-1:0] io_wr_val;

    // Clamp an I/O size write to the size of the host I/O space.
    always_comb begin
        if (cfg_wdata > CFG_DW'(IO_AW)) begin
            io_wr_val = IO_MAX;
        end else begin
            io_wr_val = cfg_wdata[IOSZ_W-1:0];
        end
    end

    // Register update on a write strobe; read-only and unused offsets ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            np_base <= '0;
            np_ctl  <= '0;
            pf_base <= '0;
            pf_ctl  <= '0;
            io_size <= IO_MAX;
        end else if (cfg_wr_en) begin
            case (cfg_addr)
                CFG_AW'(REG_NP_BASE): np_base <= cfg_wdata[BASE_W-1:0];
                CFG_AW'(REG_NP_CTL):  np_ctl  <= winctl_t'(cfg_wdata[3:0]);
                CFG_AW'(REG_PF_BASE): pf_base <= cfg_wdata[BASE_W-1:0];
                CFG_AW'(REG_PF_CTL):  pf_ctl  <= winctl_t'(cfg_wdata[3:0]);
                CFG_AW'(REG_IO_SIZE): io_size <= io_wr_val;
                default: ;
            endcase
        end
    end

    // Read-back multiplexer, zero-filled above each field.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            CFG_AW'(REG_ID):      cfg_rdata[7:0]        = {MAP_TYPE_ID, CAP_TYPE_ID};
            CFG_AW'(REG_NP_BASE): cfg_rdata[BASE_W-1:0] = np_base;
            CFG_AW'(REG_NP_CTL):  cfg_rdata[3:0]        = np_ctl;
            CFG_AW'(REG_PF_BASE): cfg_rdata[BASE_W-1:0] = pf_base;
            CFG_AW'(REG_PF_CTL):  cfg_rdata[3:0]        = pf_ctl;
            CFG_AW'(REG_IO_SIZE): cfg_rdata[IOSZ_W-1:0] = io_size;
            default:              cfg_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/brwin_window.sv
// Module: one memory window matcher.
// Computes the granule offset from the base, flags a hit when the offset is
// inside a power-of-two window, translates the address and checks attributes.
// Assumes SIZE_LOG2 <= HADDR_W - GRAN_LSB; wrap-around of the granule offset is intended.
module brwin_window
    import brwin_pkg::*;
#(
    parameter int HADDR_W   = 40,
    parameter int EADDR_W   = 32,
    parameter int GRAN_LSB  = 20,
    parameter int SIZE_LOG2 = 4
) (
    input  logic [HADDR_W-1:0]          addr,
    input  logic [HADDR_W-GRAN_LSB-1:0] base,
    input  winctl_t                     ctl,
    input  attr_t                       attr,
    output logic                        hit,
    output logic                        attr_bad,
    output logic [EADDR_W-1:0]          xaddr
);

    localparam int BASE_W = HADDR_W - GRAN_LSB;

    logic [BASE_W-1:0] offs;

    // Offset, range test, attribute permit test and translation.
    always_comb begin
        offs     = addr[HADDR_W-1:GRAN_LSB] - base;
        hit      = ctl.en && ((offs >> SIZE_LOG2) == '0);
        attr_bad = |(attr & ~ctl.permit);
        xaddr    = EADDR_W'({offs, addr[GRAN_LSB-1:0]});
    end

endmodule

// File: rtl/brwin_io.sv
// Module: I/O range matcher.
// Claims an I/O offset below 2^io_size and passes the offset on as the
// expansion-bus address. Assumes IO_AW <= EADDR_W.
module brwin_io #(
    parameter int EADDR_W = 32,
    parameter int IO_AW   = 25,
    parameter int IOSZ_W  = 5
) (
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [IOSZ_W-1:0]  io_size,
    output logic               hit,
    output logic [EADDR_W-1:0] xaddr
);

    // Range test against the programmed power-of-two limit.
    always_comb begin
        hit   = ((io_addr >> io_size) == '0);
        xaddr = EADDR_W'(io_addr);
    end

endmodule

// File: rtl/brwin_decoder.sv
// Module: downstream bridge window decoder (top).
// Decodes each request against the I/O range or the two memory windows
// (non-prefetchable first), then registers the result behind a one-entry
// valid/ready output stage. Assumes configuration is stable while requests
// are in flight; changes apply to requests accepted after the write edge.
module brwin_decoder
    import brwin_pkg::*;
#(
    parameter int HADDR_W      = 40,
    parameter int EADDR_W      = 32,
    parameter int GRAN_LSB     = 20,
    parameter int NP_SIZE_LOG2 = 4,
    parameter int PF_SIZE_LOG2 = 6,
    parameter int IO_AW        = 25,
    parameter int CFG_AW       = 3,
    parameter int CFG_DW       = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    output logic [CFG_DW-1:0]  cfg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [HADDR_W-1:0] req_addr,
    input  logic               req_io,
    input  logic [2:0]         req_attr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_claim,
    output logic [1:0]         rsp_win,
    output logic [EADDR_W-1:0] rsp_addr,
    output logic               rsp_err,
    output logic               rsp_fwd
);

    localparam int BASE_W = HADDR_W - GRAN_LSB;
    localparam int IOSZ_W = $clog2(IO_AW + 1);

    logic [BASE_W-1:0]  win_base [NUM_WIN];
    winctl_t            win_ctl  [NUM_WIN];
    logic               win_hit  [NUM_WIN];
    logic               win_bad  [NUM_WIN];
    logic [EADDR_W-1:0] win_xa   [NUM_WIN];
    logic [IOSZ_W-1:0]  io_size;
    logic               io_hit;
    logic [EADDR_W-1:0] io_xa;

    logic               d_claim;
    win_e               d_win;
    logic [EADDR_W-1:0] d_addr;
    logic               d_err;

    brwin_regs #(
        .CFG_AW (CFG_AW),
        .CFG_DW (CFG_DW),
        .BASE_W (BASE_W),
        .IO_AW  (IO_AW),
        .IOSZ_W (IOSZ_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .np_base   (win_base[0]),
        .np_ctl    (win_ctl[0]),
        .pf_base   (win_base[1]),
        .pf_ctl    (win_ctl[1]),
        .io_size   (io_size)
    );

    // One matcher per memory window; index 0 is non-prefetchable, 1 prefetchable.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        brwin_window #(
            .HADDR_W   (HADDR_W),
            .EADDR_W   (EADDR_W),
            .GRAN_LSB  (GRAN_LSB),
            .SIZE_LOG2 ((w == 0) ? NP_SIZE_LOG2 : PF_SIZE_LOG2)
        ) u_win (
            .addr     (req_addr),
            .base     (win_base[w]),
            .ctl      (win_ctl[w]),
            .attr     (attr_t'(req_attr)),
            .hit      (win_hit[w]),
            .attr_bad (win_bad[w]),
            .xaddr    (win_xa[w])
        );
    end

    brwin_io #(
        .EADDR_W (EADDR_W),
        .IO_AW   (IO_AW),
        .IOSZ_W  (IOSZ_W)
    ) u_io (
        .io_addr (req_addr[IO_AW-1:0]),
        .io_size (io_size),
        .hit     (io_hit),
        .xaddr   (io_xa)
    );

    // Select the decode result: I/O path by kind, else windows in priority order.
    always_comb begin
        d_claim = 1'b0;
        d_win   = WIN_NONE;
        d_addr  = '0;
        d_err   = 1'b0;
        if (req_io) begin
            if (io_hit) begin
                d_claim = 1'b1;
                d_win   = WIN_IO;
                d_addr  = io_xa;
            end
        end else if (win_hit[0]) begin
            d_claim = 1'b1;
            d_win   = WIN_NP;
            d_addr  = win_xa[0];
            d_err   = win_bad[0];
        end else if (win_hit[1]) begin
            d_claim = 1'b1;
            d_win   = WIN_PF;
            d_addr  = win_xa[1];
            d_err   = win_bad[1];
        end
    end

    // The input can be taken when the output slot is empty or being drained.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
    end

    // One-entry output stage holding the registered decode result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_claim <= 1'b0;
            rsp_win   <= WIN_NONE;
            rsp_addr  <= '0;
            rsp_err   <= 1'b0;
            rsp_fwd   <= 1'b0;
        end else if (req_valid && req_ready) begin
            rsp_valid <= 1'b1;
            rsp_claim <= d_claim;
            rsp_win   <= d_win;
            rsp_addr  <= d_addr;
            rsp_err   <= d_err;
            rsp_fwd   <= d_claim && !d_err;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/brwin_checker.sv
// Module: protocol and consistency checker for brwin_decoder, attached by bind.
// Assumes the synchronous active-low reset of the decoder.
module brwin_checker #(
    parameter int EADDR_W = 32,
    parameter int CFG_AW  = 3,
    parameter int CFG_DW  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CFG_AW-1:0]  cfg_addr,
    input logic [CFG_DW-1:0]  cfg_rdata,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_io,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               rsp_claim,
    input logic [1:0]         rsp_win,
    input logic [EADDR_W-1:0] rsp_addr,
    input logic               rsp_err,
    input logic               rsp_fwd
);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_claim) && $stable(rsp_win)
            && $stable(rsp_addr) && $stable(rsp_err) && $stable(rsp_fwd)));

    // R10
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R7
    fwd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fwd) |-> (rsp_claim && !rsp_err));

    // R7
    err_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_claim && !rsp_fwd));

    // R9
    unclaimed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_claim) |-> (rsp_win == 2'd0 && rsp_addr == '0 && !rsp_err && !rsp_fwd));

    // R8
    io_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_io) |=> (!rsp_claim || (rsp_win == 2'd3 && !rsp_err)));

    // R1
    id_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == '0) |-> (cfg_rdata == CFG_DW'(8)));

endmodule

bind brwin_decoder brwin_checker #(
    .EADDR_W (EADDR_W),
    .CFG_AW  (CFG_AW),
    .CFG_DW  (CFG_DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_io    (req_io),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_claim (rsp_claim),
    .rsp_win   (rsp_win),
    .rsp_addr  (rsp_addr),
    .rsp_err   (rsp_err),
    .rsp_fwd   (rsp_fwd)
);

// File: tb/brwin_decoder_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task computes the expected response from the
// requirements and queues it; a monitor pops and compares each response.
module brwin_decoder_tb;

    localparam int NPL = 2;
    localparam int PFL = 3;

    typedef struct packed {
        logic        claim;
        logic [1:0]  win;
        logic [31:0] addr;
        logic        err;
        logic        fwd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic [2:0]  req_attr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_claim;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;
    logic        rsp_err;
    logic        rsp_fwd;

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;
    bit stall = 0;
    int cyc = 0;

    exp_t  eq[$];
    string tq[$];

    logic [19:0] sh_np_base = '0, sh_pf_base = '0;
    logic [3:0]  sh_np_ctl = '0, sh_pf_ctl = '0;
    int          sh_io = 25;

    brwin_decoder #(
        .NP_SIZE_LOG2 (NPL),
        .PF_SIZE_LOG2 (PFL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_io(req_io),
        .req_attr(req_attr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_claim(rsp_claim), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
        .rsp_err(rsp_err), .rsp_fwd(rsp_fwd)
    );

    always #10 clk = ~clk;

    // Response-ready pattern: always ready, or stalled one cycle in three.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        rsp_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end

    function automatic exp_t model(input logic [39:0] a, input logic io, input logic [2:0] at);
        exp_t e;
        logic [63:0] lo, hi, a64;
        logic [24:0] off;
        e = '0;
        a64 = {24'h0, a};
        if (io) begin
            off = a[24:0];
            if ({39'h0, off} < (64'd1 << sh_io)) begin
                e.claim = 1; e.win = 2'd3; e.addr = {7'h0, off}; e.fwd = 1;
            end
        end else begin
            lo = {24'h0, sh_np_base, 20'h0};
            hi = lo + (64'd1 << (20 + NPL));
            if (sh_np_ctl[0] && a64 >= lo && a64 < hi) begin
                e.claim = 1; e.win = 2'd1; e.addr = 32'(a64 - lo);
                e.err = |(at & ~sh_np_ctl[3:1]);
            end else begin
                lo = {24'h0, sh_pf_base, 20'h0};
                hi = lo + (64'd1 << (20 + PFL));
                if (sh_pf_ctl[0] && a64 >= lo && a64 < hi) begin
                    e.claim = 1; e.win = 2'd2; e.addr = 32'(a64 - lo);
                    e.err = |(at & ~sh_pf_ctl[3:1]);
                end
            end
            e.fwd = e.claim && !e.err;
        end
        return e;
    endfunction

    task automatic send(input logic [39:0] a, input logic io, input logic [2:0] at, input string tag);
        @(posedge clk); #1;
        req_valid = 1; req_addr = a; req_io = io; req_attr = at;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        eq.push_back(model(a, io, at));
        tq.push_back(tag);
        @(posedge clk); #1;
        req_valid = 0;
        nchk++;
        if (rsp_valid !== 1'b1) begin
            nbad++;
            $display("FAIL R10 latency (%s): rsp_valid=%b expected 1", tag, rsp_valid);
        end
    endtask

    task automatic drain();
        while (eq.size() != 0 || rsp_valid) @(negedge clk);
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] d);
        drain();
        @(posedge clk); #1;
        cfg_wr_en = 1; cfg_addr = a[2:0]; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr_en = 0;
    endtask

    task automatic cfg_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a[2:0];
        #1;
        nchk++;
        if (cfg_rdata !== exp) begin
            nbad++;
            $display("FAIL %s: reg %0d actual=%h expected=%h", tag, a, cfg_rdata, exp);
        end
    endtask

    // Monitor: hold check while stalled, then scoreboard compare on each handshake.
    exp_t snap;
    bit   hold_prev = 0;
    always @(negedge clk) begin
        exp_t cur, e;
        string t;
        if (rst_n) begin
            cur = '{rsp_claim, rsp_win, rsp_addr, rsp_err, rsp_fwd};
            if (hold_prev) begin
                nchk++;
                if (!rsp_valid || cur !== snap) begin
                    nbad++;
                    $display("FAIL R10 hold: actual=%h expected=%h", cur, snap);
                end
            end
            hold_prev = rsp_valid && !rsp_ready;
            snap = cur;
            if (rsp_valid && rsp_ready) begin
                if (eq.size() == 0) begin
                    nbad++;
                    $display("FAIL R10 unexpected response: actual=%h expected none", cur);
                end else begin
                    e = eq.pop_front();
                    t = tq.pop_front();
                    nchk++;
                    if (cur !== e) begin
                        nbad++;
                        $display("FAIL %s: actual claim=%b win=%0d addr=%h err=%b fwd=%b expected claim=%b win=%0d addr=%h err=%b fwd=%b",
                            t, cur.claim, cur.win, cur.addr, cur.err, cur.fwd,
                            e.claim, e.win, e.addr, e.err, e.fwd);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nbad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        nchk++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            nbad++;
            $display("FAIL R10 reset: rsp_valid=%b req_ready=%b expected 0/1", rsp_valid, req_ready);
        end
        // R1 and R2: identification word and reset values
        cfg_chk(0, 32'h8, "R1 id");
        cfg_chk(1, 32'h0, "R2 np base reset");
        cfg_chk(2, 32'h0, "R2 np ctl reset");
        cfg_chk(3, 32'h0, "R2 pf base reset");
        cfg_chk(4, 32'h0, "R2 pf ctl reset");
        cfg_chk(5, 32'd25, "R2 io size reset");
        cfg_wr(0, 32'hFFFF_FFFF);
        cfg_chk(0, 32'h8, "R1 id write ignored");
        cfg_wr(7, 32'hFFFF_FFFF);
        cfg_chk(7, 32'h0, "R1 unused offset");
        // R5: reset windows have base 0 but are disabled
        send(40'h00_0000_0100, 0, 3'b000, "R5 disabled at reset");
        // Program overlapping windows
        cfg_wr(1, 32'hFFF1_2345); sh_np_base = 20'h12345;
        cfg_wr(2, 32'hFFFF_FFFF); sh_np_ctl = 4'hF;
        cfg_wr(3, 32'h0001_2347); sh_pf_base = 20'h12347;
        cfg_wr(4, 32'h0000_000F); sh_pf_ctl = 4'hF;
        cfg_chk(1, 32'h0001_2345, "R2 np base masked");
        cfg_chk(2, 32'h0000_000F, "R2 np ctl masked");
        // R3 / R4 / R6 / R9: window hits, edges and overlap
        send(40'h12_3450_0010, 0, 3'b000, "R3 np first");
        send(40'h12_346A_BCDE, 0, 3'b111, "R3 np middle");
        send(40'h12_3470_0004, 0, 3'b000, "R6 overlap np wins");
        send(40'h12_348F_FFFF, 0, 3'b000, "R3 np last byte");
        send(40'h12_3490_0000, 0, 3'b000, "R4 pf after np");
        send(40'h12_34EF_FFFF, 0, 3'b000, "R4 pf last byte");
        send(40'h12_34F0_0000, 0, 3'b000, "R9 above pf");
        send(40'h12_344F_FFFF, 0, 3'b000, "R9 below np");
        // R7: attribute permits
        cfg_wr(2, 32'h3); sh_np_ctl = 4'h3;
        cfg_wr(4, 32'h1); sh_pf_ctl = 4'h1;
        send(40'h12_3450_0000, 0, 3'b010, "R7 np iso denied");
        send(40'h12_3450_0000, 0, 3'b001, "R7 np noncoh allowed");
        send(40'h12_3470_0000, 0, 3'b010, "R7 overlap denied in np");
        send(40'h12_34A0_0000, 0, 3'b000, "R7 pf plain allowed");
        send(40'h12_34A0_0000, 0, 3'b100, "R7 pf compat denied");
        // R5: disabling np exposes pf in the overlap
        cfg_wr(2, 32'hE); sh_np_ctl = 4'hE;
        send(40'h12_3470_0000, 0, 3'b000, "R5 np disabled");
        send(40'h12_3450_0000, 0, 3'b000, "R5 np disabled no claim");
        // R8: I/O range
        send(40'h00_01FF_FFFF, 1, 3'b111, "R8 io full range top");
        send(40'hFF_0000_0010, 1, 3'b000, "R8 io upper bits ignored");
        cfg_wr(5, 32'd12); sh_io = 12;
        send(40'h00_0000_0FFF, 1, 3'b000, "R8 io last in range");
        send(40'h00_0000_1000, 1, 3'b000, "R8 io first out of range");
        cfg_wr(5, 32'd31); sh_io = 25;
        cfg_chk(5, 32'd25, "R8 io size clamp");
        cfg_wr(5, 32'd0); sh_io = 0;
        send(40'h00_0000_0000, 1, 3'b000, "R8 io size 0 hit");
        send(40'h00_0000_0001, 1, 3'b000, "R8 io size 0 miss");
        // R10: burst under backpressure
        cfg_wr(2, 32'hF); sh_np_ctl = 4'hF;
        stall = 1;
        for (int i = 0; i < 12; i++) begin
            send(40'h12_3450_0000 + 40'(i) * 40'h8_1234, (i % 4) == 3, 3'(i), "R10 burst");
        end
        drain();
        stall = 0;
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule